// File: doc/BRIEF.md
# Translation Lookaside Buffer

This block caches recent page-table translations for a 32-bit paged memory unit. An access address is split into a 20-bit virtual page number (bits 31:12) and a 12-bit page offset (bits 11:0). The page number is compared against every valid slot at once, as in a content-addressable memory. A matching slot returns its 20-bit frame number and its five permission/status flags in the same cycle, with no register on the lookup path. A lookup that matches no slot raises a miss and translates nothing. An external page-table walker or trap handler then fetches the entry and writes it in through the fill port.

Fills go to the slot named by a round-robin victim pointer. When the incoming page number is already cached, the fill goes to that slot instead. A flush input clears the whole cache when the running process changes.

The lookup outcome is an enumerated result with four values. RES_IDLE means no lookup was requested. RES_MISS means no valid slot matched. RES_FAULT means a slot matched but the access broke its permissions. RES_HIT means a slot matched and the access is allowed. The outcome is recomputed every cycle from the request and the stored slots. The stored slots change only on a fill or a flush. Between fills the victim pointer stays put. On each accepted fill it moves to the next slot, wrapping after the last. A flush returns it to slot 0.

Top module: `xlat_cache`

## Requirements
- R1: On a hit, `paddr` equals the cached 20-bit frame number in bits 31:12, joined with `lookup_vaddr[11:0]` unchanged in bits 11:0.
- R2: A hit is reported in the same cycle as the request. `hit_flags` then carries the slot's flags, encoded as bit 0 present, bit 1 writable, bit 2 user-accessible, bit 3 referenced, bit 4 dirty.
- R3: When no valid slot holds the requested page number, `miss` is 1 and `hit`, `prot_fault`, `paddr` and `hit_flags` are 0.
- R4: A write (`lookup_write`=1) that matches a slot whose writable flag (bit 1) is 0 gives `prot_fault`=1, `hit`=0 and `paddr`=0.
- R5: A user access (`lookup_user`=1) that matches a slot whose user flag (bit 2) is 0 gives `prot_fault`=1, `hit`=0 and `paddr`=0.
- R6: With 8 slots, a fill of a new page number writes the slot under the victim pointer. The pointer moves one slot after every accepted fill and wraps, so the ninth distinct fill after reset replaces the first.
- R7: A fill whose page number is already cached overwrites that slot. The page number never occupies two slots.
- R8: Flush invalidates every slot and returns the victim pointer to slot 0. A fill presented in the same cycle as a flush is dropped.
- R9: After reset every slot is invalid, so every lookup misses, and the victim pointer is at slot 0.
- R10: With `lookup_valid`=0, `hit`, `miss`, `prot_fault`, `paddr` and `hit_flags` are all 0.
- R11: A fill takes effect at the next clock edge. A lookup in the same cycle as the fill still sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all slots |
| lookup_valid | input | 1 | Lookup request |
| lookup_vaddr | input | 32 | Virtual address to translate |
| lookup_write | input | 1 | Access is a write |
| lookup_user | input | 1 | Access is from user mode |
| hit | output | 1 | Valid translation returned |
| miss | output | 1 | No cached translation |
| prot_fault | output | 1 | Matching slot forbids this access |
| paddr | output | 32 | Translated physical address |
| hit_flags | output | 5 | Flags of the matching slot on a hit |
| fill_valid | input | 1 | Write a translation |
| fill_vpn | input | 20 | Page number of the fill |
| fill_pfn | input | 20 | Frame number of the fill |
| fill_flags | input | 5 | Flags of the fill |

## Verification
The assertions check several properties on every cycle:
- At most one of hit, miss and fault is raised.
- A hit keeps the page offset.
- A fault only appears on a write or user access.
- No two slots ever match one page number.
- A lookup right after a flush misses.
- A supervisor read right after a fill returns the filled frame.

Only the bench scenarios can show the following, because they need the history of many fills:
- The round-robin eviction order, including a pointer advance on a duplicate fill.
- The overwrite of a re-filled page.
- The exact flags and frames returned across long random runs.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
    parameter int VA_W  = 32;
    parameter int OFS_W = 12;
    parameter int PFN_W = 20;
    parameter int FLG_W = 5;
    localparam int VPN_W = VA_W - OFS_W;

    localparam int FLG_PRESENT = 0;
    localparam int FLG_WRITE   = 1;
    localparam int FLG_USER    = 2;
    localparam int FLG_REF     = 3;
    localparam int FLG_DIRTY   = 4;

    typedef struct packed {
        logic             valid;
        logic [VPN_W-1:0] vpn;
        logic [PFN_W-1:0] pfn;
        logic [FLG_W-1:0] flags;
    } slot_t;

    typedef enum logic [1:0] {
        RES_IDLE  = 2'd0,
        RES_HIT   = 2'd1,
        RES_MISS  = 2'd2,
        RES_FAULT = 2'd3
    } res_e;
endpackage

// File: rtl/xlat_victim.sv
module xlat_victim #(
    parameter int SLOTS = 8,
    localparam int IDX_W = $clog2(SLOTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             fill_valid,
    output logic [IDX_W-1:0] ptr
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(SLOTS - 1);

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            ptr <= '0;
        end else if (fill_valid) begin
            ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
        end
    end
endmodule

// File: rtl/xlat_match.sv
module xlat_match #(
    parameter int SLOTS = 8,
    localparam int IDX_W = $clog2(SLOTS)
) (
    input  xlat_pkg::slot_t [SLOTS-1:0]       slots,
    input  logic [xlat_pkg::VPN_W-1:0]        key,
    output logic [SLOTS-1:0]                  match_vec,
    output logic                              any,
    output logic [IDX_W-1:0]                  idx
);
    for (genvar g = 0; g < SLOTS; g++) begin : g_cmp
        assign match_vec[g] = slots[g].valid && (slots[g].vpn == key);
    end

    assign any = |match_vec;

    always_comb begin
        idx = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (match_vec[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/xlat_store.sv
module xlat_store #(
    parameter int SLOTS = 8,
    localparam int IDX_W = $clog2(SLOTS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        flush,
    input  logic                        wr_en,
    input  logic [IDX_W-1:0]            wr_idx,
    input  logic [xlat_pkg::VPN_W-1:0]  wr_vpn,
    input  logic [xlat_pkg::PFN_W-1:0]  wr_pfn,
    input  logic [xlat_pkg::FLG_W-1:0]  wr_flags,
    output xlat_pkg::slot_t [SLOTS-1:0] slots
);
    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n || flush) begin
                slots[g] <= '0;
            end else if (wr_en && wr_idx == IDX_W'(g)) begin
                slots[g].valid <= 1'b1;
                slots[g].vpn   <= wr_vpn;
                slots[g].pfn   <= wr_pfn;
                slots[g].flags <= wr_flags;
            end
        end
    end
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache #(
    parameter int SLOTS = 8,
    localparam int IDX_W = $clog2(SLOTS),
    localparam int VA_W  = xlat_pkg::VA_W,
    localparam int OFS_W = xlat_pkg::OFS_W,
    localparam int VPN_W = xlat_pkg::VPN_W,
    localparam int PFN_W = xlat_pkg::PFN_W,
    localparam int FLG_W = xlat_pkg::FLG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             lookup_valid,
    input  logic [VA_W-1:0]  lookup_vaddr,
    input  logic             lookup_write,
    input  logic             lookup_user,
    output logic             hit,
    output logic             miss,
    output logic             prot_fault,
    output logic [VA_W-1:0]  paddr,
    output logic [FLG_W-1:0] hit_flags,
    input  logic             fill_valid,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PFN_W-1:0] fill_pfn,
    input  logic [FLG_W-1:0] fill_flags
);
    import xlat_pkg::*;

    slot_t [SLOTS-1:0] slots;
    logic [SLOTS-1:0]  slot_hit;
    logic [SLOTS-1:0]  dup_vec;
    logic              look_any;
    logic              dup_any;
    logic [IDX_W-1:0]  look_idx;
    logic [IDX_W-1:0]  dup_idx;
    logic [IDX_W-1:0]  victim;
    logic [IDX_W-1:0]  fill_idx;
    logic              fill_go;
    slot_t             sel;
    logic              denied;
    res_e              res;

    assign fill_go  = fill_valid && !flush;
    assign fill_idx = dup_any ? dup_idx : victim;

    xlat_victim #(.SLOTS(SLOTS)) u_victim (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .fill_valid(fill_go), .ptr(victim)
    );

    xlat_store #(.SLOTS(SLOTS)) u_store (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .wr_en(fill_go), .wr_idx(fill_idx),
        .wr_vpn(fill_vpn), .wr_pfn(fill_pfn), .wr_flags(fill_flags),
        .slots(slots)
    );

    xlat_match #(.SLOTS(SLOTS)) u_look (
        .slots(slots), .key(lookup_vaddr[VA_W-1:OFS_W]),
        .match_vec(slot_hit), .any(look_any), .idx(look_idx)
    );

    xlat_match #(.SLOTS(SLOTS)) u_dup (
        .slots(slots), .key(fill_vpn),
        .match_vec(dup_vec), .any(dup_any), .idx(dup_idx)
    );

    assign sel    = slots[look_idx];
    assign denied = (lookup_write && !sel.flags[FLG_WRITE]) ||
                    (lookup_user  && !sel.flags[FLG_USER]);

    // result classification
    always_comb begin
        if (!lookup_valid)  res = RES_IDLE;
        else if (!look_any) res = RES_MISS;
        else if (denied)    res = RES_FAULT;
        else                res = RES_HIT;
    end

    // outputs per result
    always_comb begin
        hit        = 1'b0;
        miss       = 1'b0;
        prot_fault = 1'b0;
        paddr      = '0;
        hit_flags  = '0;
        unique case (res)
            RES_IDLE:  ;
            RES_MISS:  miss = 1'b1;
            RES_FAULT: prot_fault = 1'b1;
            RES_HIT: begin
                hit       = 1'b1;
                paddr     = {sel.pfn, lookup_vaddr[OFS_W-1:0]};
                hit_flags = sel.flags;
            end
        endcase
    end
endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
    parameter int SLOTS = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              flush,
    input logic              fill_valid,
    input logic [19:0]       fill_vpn,
    input logic [19:0]       fill_pfn,
    input logic              lookup_valid,
    input logic [31:0]       lookup_vaddr,
    input logic              lookup_write,
    input logic              lookup_user,
    input logic              hit,
    input logic              miss,
    input logic              prot_fault,
    input logic [31:0]       paddr,
    input logic [SLOTS-1:0]  match_vec
);
    p_one_result_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({hit, miss, prot_fault}));

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !lookup_valid |-> (!hit && !miss && !prot_fault && paddr == '0));

    p_offset_kept_r1: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> paddr[11:0] == lookup_vaddr[11:0]);

    p_fault_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        prot_fault |-> (lookup_write || lookup_user));

    p_no_dup_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match_vec));

    p_flush_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!lookup_valid || miss));

    p_fill_visible_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && !flush) |=>
            (!(lookup_valid && lookup_vaddr[31:12] == $past(fill_vpn) &&
               !lookup_write && !lookup_user) ||
             (hit && paddr[31:12] == $past(fill_pfn))));
endmodule

bind xlat_cache xlat_cache_chk #(.SLOTS(SLOTS)) u_chk (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
    .lookup_valid(lookup_valid), .lookup_vaddr(lookup_vaddr),
    .lookup_write(lookup_write), .lookup_user(lookup_user),
    .hit(hit), .miss(miss), .prot_fault(prot_fault), .paddr(paddr),
    .match_vec(slot_hit)
);

// File: tb/xlat_cache_bench.sv
`timescale 1ns/1ps
module xlat_cache_bench;
    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        lookup_valid = 1'b0;
    logic [31:0] lookup_vaddr = '0;
    logic        lookup_write = 1'b0;
    logic        lookup_user = 1'b0;
    logic        hit, miss, prot_fault;
    logic [31:0] paddr;
    logic [4:0]  hit_flags;
    logic        fill_valid = 1'b0;
    logic [19:0] fill_vpn = '0;
    logic [19:0] fill_pfn = '0;
    logic [4:0]  fill_flags = '0;

    int checks = 0;
    int errors = 0;

    logic        m_val [N];
    logic [19:0] m_vpn [N];
    logic [19:0] m_pfn [N];
    logic [4:0]  m_flg [N];
    int          m_ptr;

    always #2 clk = ~clk;

    xlat_cache u_xlat_cache (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .lookup_valid(lookup_valid), .lookup_vaddr(lookup_vaddr),
        .lookup_write(lookup_write), .lookup_user(lookup_user),
        .hit(hit), .miss(miss), .prot_fault(prot_fault),
        .paddr(paddr), .hit_flags(hit_flags),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn),
        .fill_pfn(fill_pfn), .fill_flags(fill_flags)
    );

    function automatic int find(input logic [19:0] v);
        for (int i = 0; i < N; i++) if (m_val[i] && m_vpn[i] == v) return i;
        return -1;
    endfunction

    // {hit, miss, fault, paddr, flags}
    function automatic logic [39:0] expect_out(input logic lv, input logic [31:0] va,
                                               input logic wr, input logic us);
        int k;
        if (!lv) return '0;
        k = find(va[31:12]);
        if (k < 0) return {3'b010, 32'h0, 5'h0};
        if ((wr && !m_flg[k][1]) || (us && !m_flg[k][2])) return {3'b001, 32'h0, 5'h0};
        return {3'b100, m_pfn[k], va[11:0], m_flg[k]};
    endfunction

    function automatic string auto_tag(input logic lv, input logic [31:0] va,
                                       input logic wr, input logic us);
        int k;
        if (!lv) return "R10";
        k = find(va[31:12]);
        if (k < 0) return "R3";
        if (wr && !m_flg[k][1]) return "R4";
        if (us && !m_flg[k][2]) return "R5";
        return "R2";
    endfunction

    task automatic model_update();
        int k;
        if (flush) begin
            for (int i = 0; i < N; i++) m_val[i] = 1'b0;
            m_ptr = 0;
        end else if (fill_valid) begin
            k = find(fill_vpn);
            if (k < 0) k = m_ptr;
            m_val[k] = 1'b1; m_vpn[k] = fill_vpn; m_pfn[k] = fill_pfn; m_flg[k] = fill_flags;
            m_ptr = (m_ptr + 1) % N;
        end
    endtask

    task automatic step(input string tag, input logic lv, input logic [31:0] va,
                        input logic wr, input logic us, input logic fv,
                        input logic [19:0] fvpn, input logic [19:0] fpfn,
                        input logic [4:0] fflg, input logic fl);
        logic [39:0] e, a;
        string t;
        @(negedge clk);
        lookup_valid = lv; lookup_vaddr = va; lookup_write = wr; lookup_user = us;
        fill_valid = fv; fill_vpn = fvpn; fill_pfn = fpfn; fill_flags = fflg; flush = fl;
        #1;
        e = expect_out(lv, va, wr, us);
        a = {hit, miss, prot_fault, paddr, hit_flags};
        t = (tag == "") ? auto_tag(lv, va, wr, us) : tag;
        checks++;
        if (a !== e) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", t, a, e);
        end
        @(posedge clk);
        #0 model_update();
    endtask

    task automatic look(input string tag, input logic [31:0] va, input logic wr, input logic us);
        step(tag, 1'b1, va, wr, us, 1'b0, '0, '0, '0, 1'b0);
    endtask

    task automatic fill(input string tag, input logic [19:0] v, input logic [19:0] p,
                        input logic [4:0] f);
        step(tag, 1'b0, '0, 1'b0, 1'b0, 1'b1, v, p, f, 1'b0);
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int unused;
        unused = $urandom(32'd20240611);
        for (int i = 0; i < N; i++) m_val[i] = 1'b0;
        m_ptr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R9 after reset nothing hits
        look("R9", 32'h0000_5abc, 1'b0, 1'b0);
        step("R10", 1'b0, 32'h0000_5abc, 1'b0, 1'b0, 1'b0, '0, '0, '0, 1'b0);

        // R11 same-cycle fill invisible, then R1 R2 hit
        step("R11", 1'b1, 32'h1234_5678, 1'b0, 1'b0, 1'b1, 20'h12345, 20'hABCDE, 5'b00111, 1'b0);
        look("R1", 32'h1234_5678, 1'b0, 1'b0);
        look("R2", 32'h1234_5fff, 1'b1, 1'b1);

        // R4 R5 protection
        fill("R6", 20'h00042, 20'h00777, 5'b11001);
        look("R4", 32'h0004_2010, 1'b1, 1'b0);
        look("R5", 32'h0004_2010, 1'b0, 1'b1);
        look("R2", 32'h0004_2010, 1'b0, 1'b0);

        // R8 flush wins over same-cycle fill
        step("R8", 1'b0, '0, 1'b0, 1'b0, 1'b1, 20'h00999, 20'h00111, 5'b00111, 1'b1);
        look("R8", 32'h1234_5000, 1'b0, 1'b0);
        look("R8", 32'h0099_9000, 1'b0, 1'b0);

        // R6 round robin, R7 duplicate overwrite
        for (int i = 0; i < N; i++) fill("R6", 20'h100 + 20'(i), 20'h800 + 20'(i), 5'b00111);
        for (int i = 0; i < N; i++) look("R6", {20'h100 + 20'(i), 12'h3c0}, 1'b0, 1'b0);
        fill("R7", 20'h100, 20'hFEED0, 5'b10111);
        look("R7", 32'h0010_0004, 1'b0, 1'b1);
        fill("R6", 20'h200, 20'h0BEEF, 5'b00111);
        look("R6", 32'h0010_1000, 1'b0, 1'b0);
        look("R6", 32'h0020_0abc, 1'b0, 1'b0);
        look("R6", 32'h0010_2000, 1'b0, 1'b0);

        // random phase
        for (int n = 0; n < 3000; n++) begin
            logic [19:0] v, lv20;
            logic lv, fv, fl;
            v    = 20'h300 + 20'($urandom_range(0, 13));
            lv20 = 20'h300 + 20'($urandom_range(0, 13));
            lv   = ($urandom_range(0, 9) != 0);
            fv   = ($urandom_range(0, 3) == 0);
            fl   = ($urandom_range(0, 99) == 0);
            step("", lv, {lv20, 12'($urandom)}, 1'($urandom), 1'($urandom),
                 fv, v, 20'($urandom), 5'($urandom), fl);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule